// File: doc/BRIEF.md
# Not-Recently-Used Page Victim Selector

This block keeps two usage flags for each resident page frame: a referenced flag and a dirty flag. The memory pipeline reports every access to a frame, along with whether it was a store. A periodic tick from a timer wipes the referenced flags, so a flag that is set means the frame was used during the current interval. The dirty flags survive the tick, because they record whether the frame has to be written out before it is reused.

When the fault handler needs a frame, it pulses a request. The block sorts every frame into one of four classes by its two flags and selects a frame from the lowest class that has any members. A free-running LFSR chooses where the search within that class starts, so repeated faults spread their victims across the class. The frame index comes back one cycle after the request, together with a valid flag. Fetching the new page and writing the old one back are handled by other blocks.

Top module: `nru_victim_sel`

## Requirements
- R1: An access strobe sets the referenced flag of the indexed frame, whether the access is a read or a write.
- R2: An access with the write flag high also sets the dirty flag of that frame.
- R3: While rst_ni is low, every referenced flag and dirty flag is cleared and victim_valid_o is 0. After reset, no frame carries a flag from before the reset.
- R4: A tick clears every referenced flag and leaves every dirty flag unchanged.
- R5: The class of a frame is 2 × referenced + dirty. Class 0 is idle and clean, and class 3 is used and dirty. The victim always comes from the lowest-numbered class that has at least one frame in it.
- R6: Within the winning class, the block selects the first member found by scanning upward from the current LFSR value, wrapping past the top frame. The LFSR is 4 bits and advances every cycle, so repeated faults over a uniform population return varying frames.
- R7: victim_o and victim_valid_o are registered. victim_valid_o is high exactly in the cycle after the cycle in which fault_req_i is high, and low otherwise.
- R8: If an access and a tick arrive in the same cycle, the accessed frame keeps its referenced flag set. All other referenced flags are cleared.
- R9: A fault request selects its victim from the flags as they stood before any access that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe |
| acc_frame_i | input | 4 | Index of the frame accessed |
| acc_write_i | input | 1 | Access is a store |
| tick_i | input | 1 | Periodic clear of the referenced flags |
| fault_req_i | input | 1 | Request for a victim frame |
| victim_o | output | 4 | Index of the selected frame |
| victim_valid_o | output | 1 | victim_o is valid this cycle |

## Verification
The assertions check on every cycle that:
- an access sets its flags;
- a tick keeps the dirty flags and clears the referenced flags, except that a coinciding access keeps its own flag;
- the valid flag follows the request by exactly one cycle;
- no idle, clean frame is passed over.

Only the bench scenarios can show the full class ordering between classes 1, 2 and 3, because that depends on long histories of accesses and ticks. The same holds for the spread of victims across a uniform class, the use of pre-access state on a colliding request, and the clearing of old history by a reset in mid-run.

// File: rtl/nru_pkg.sv
package nru_pkg;
  typedef enum logic [1:0] {
    CAT_IDLE_CLEAN = 2'd0,
    CAT_IDLE_DIRTY = 2'd1,
    CAT_USED_CLEAN = 2'd2,
    CAT_USED_DIRTY = 2'd3
  } nru_cat_e;

  localparam int unsigned NUM_CATS = 4;

  function automatic nru_cat_e cat_of(input logic ref_b, input logic mod_b);
    return nru_cat_e'({ref_b, mod_b});
  endfunction
endpackage

// File: rtl/nru_usage_bits.sv
module nru_usage_bits #(
  parameter int unsigned NUM_FRAMES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  acc_valid_i,
  input  logic [IDX_W-1:0]      acc_frame_i,
  input  logic                  acc_write_i,
  input  logic                  tick_i,
  output logic [NUM_FRAMES-1:0] ref_o,
  output logic [NUM_FRAMES-1:0] mod_o
);
  logic [NUM_FRAMES-1:0] ref_q, mod_q;
  logic [NUM_FRAMES-1:0] hit;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    assign hit[g] = acc_valid_i && (acc_frame_i == IDX_W'(g));

    // access wins over tick for the touched frame
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ref_q[g] <= 1'b0;
        mod_q[g] <= 1'b0;
      end else begin
        if (hit[g])      ref_q[g] <= 1'b1;
        else if (tick_i) ref_q[g] <= 1'b0;
        if (hit[g] && acc_write_i) mod_q[g] <= 1'b1;
      end
    end
  end

  assign ref_o = ref_q;
  assign mod_o = mod_q;
endmodule

// File: rtl/nru_lfsr.sv
module nru_lfsr #(
  parameter int unsigned  WIDTH = 4,
  parameter logic [WIDTH-1:0] TAPS = WIDTH'('hC),
  parameter logic [WIDTH-1:0] SEED = WIDTH'(1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] state_q;
  logic             fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {state_q[WIDTH-2:0], fb};
  end

  assign state_o = state_q;
endmodule

// File: rtl/nru_picker.sv
module nru_picker
  import nru_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic [NUM_FRAMES-1:0] ref_i,
  input  logic [NUM_FRAMES-1:0] mod_i,
  input  logic [IDX_W-1:0]      start_i,
  output logic [IDX_W-1:0]      pick_o
);
  nru_cat_e             cat   [NUM_FRAMES];
  logic [NUM_CATS-1:0]  present;
  nru_cat_e             best;
  logic                 found;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cat
    assign cat[g] = cat_of(ref_i[g], mod_i[g]);
  end

  always_comb begin
    present = '0;
    for (int i = 0; i < NUM_FRAMES; i++) present[cat[i]] = 1'b1;
  end

  // lowest populated class
  always_comb begin
    best = CAT_USED_DIRTY;
    for (int c = NUM_CATS - 1; c >= 0; c--)
      if (present[c]) best = nru_cat_e'(c);
  end

  // first member of best class at or above start, with wrap
  always_comb begin
    logic [IDX_W-1:0] idx;
    pick_o = start_i;
    found  = 1'b0;
    for (int o = 0; o < NUM_FRAMES; o++) begin
      idx = start_i + IDX_W'(o);
      if (!found && cat[idx] == best) begin
        pick_o = idx;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
  parameter int unsigned NUM_FRAMES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic [IDX_W-1:0] acc_frame_i,
  input  logic             acc_write_i,
  input  logic             tick_i,
  input  logic             fault_req_i,
  output logic [IDX_W-1:0] victim_o,
  output logic             victim_valid_o
);
  logic [NUM_FRAMES-1:0] ref_bits, mod_bits;
  logic [IDX_W-1:0]      lfsr_val, pick;
  logic [IDX_W-1:0]      victim_q;
  logic                  valid_q;

  nru_usage_bits #(.NUM_FRAMES(NUM_FRAMES)) u_bits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_valid_i(acc_valid_i),
    .acc_frame_i(acc_frame_i),
    .acc_write_i(acc_write_i),
    .tick_i     (tick_i),
    .ref_o      (ref_bits),
    .mod_o      (mod_bits)
  );

  nru_lfsr #(.WIDTH(IDX_W)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_o(lfsr_val)
  );

  nru_picker #(.NUM_FRAMES(NUM_FRAMES)) u_pick (
    .ref_i  (ref_bits),
    .mod_i  (mod_bits),
    .start_i(lfsr_val),
    .pick_o (pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= fault_req_i;
      if (fault_req_i) victim_q <= pick;
    end
  end

  assign victim_o       = victim_q;
  assign victim_valid_o = valid_q;
endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
  parameter int unsigned NUM_FRAMES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_FRAMES)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  acc_valid_i,
  input logic [IDX_W-1:0]      acc_frame_i,
  input logic                  acc_write_i,
  input logic                  tick_i,
  input logic                  fault_req_i,
  input logic [IDX_W-1:0]      victim_o,
  input logic                  victim_valid_o,
  input logic [NUM_FRAMES-1:0] ref_bits,
  input logic [NUM_FRAMES-1:0] mod_bits
);
  logic [NUM_FRAMES-1:0] ref_d, mod_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_d <= '0;
      mod_d <= '0;
    end else begin
      ref_d <= ref_bits;
      mod_d <= mod_bits;
    end
  end

  a_r1_access_sets_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> ref_bits[$past(acc_frame_i)]);

  a_r2_write_sets_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i) |=> mod_bits[$past(acc_frame_i)]);

  a_r4_tick_keeps_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !acc_valid_i) |=> (mod_bits == $past(mod_bits)) && (ref_bits == '0));

  a_r8_access_beats_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && acc_valid_i) |=> (ref_bits == (NUM_FRAMES'(1) << $past(acc_frame_i))));

  a_r7_valid_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_req_i |=> victim_valid_o);

  a_r7_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_req_i |=> !victim_valid_o);

  a_r5_idle_clean_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (victim_valid_o && (|(~ref_d & ~mod_d))) |-> (!ref_d[victim_o] && !mod_d[victim_o]));
endmodule

bind nru_victim_sel nru_victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .acc_valid_i   (acc_valid_i),
  .acc_frame_i   (acc_frame_i),
  .acc_write_i   (acc_write_i),
  .tick_i        (tick_i),
  .fault_req_i   (fault_req_i),
  .victim_o      (victim_o),
  .victim_valid_o(victim_valid_o),
  .ref_bits      (ref_bits),
  .mod_bits      (mod_bits)
);

// File: tb/tb_nru_victim_sel.sv
module tb_nru_victim_sel;
  localparam int NF = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       acc_valid_i = 1'b0;
  logic [3:0] acc_frame_i = '0;
  logic       acc_write_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       fault_req_i = 1'b0;
  logic [3:0] victim_o;
  logic       victim_valid_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [NF-1:0] m_ref = '0, m_mod = '0;

  always #4 clk_i = ~clk_i;

  nru_victim_sel #(.NUM_FRAMES(NF)) dut (.*);

  // step: op[23:21], mask[20:5], exp[4:0] (exp 16 = class check only)
  localparam int OP_RD = 0, OP_WR = 1, OP_TICK = 2, OP_FAULT = 3, OP_TICKRD = 4;
  localparam int N_STEPS = 12;
  localparam logic [23:0] STEPS [N_STEPS] = '{
    {3'(OP_RD),    16'hFFDF, 5'd16},
    {3'(OP_FAULT), 16'h0000, 5'd5 },   // R1
    {3'(OP_WR),    16'hFF7F, 5'd16},
    {3'(OP_FAULT), 16'h0000, 5'd7 },   // R2, R5 class 2 below 3
    {3'(OP_TICK),  16'h0000, 5'd16},
    {3'(OP_FAULT), 16'h0000, 5'd7 },   // R4 class 0 below 1
    {3'(OP_WR),    16'h0080, 5'd16},
    {3'(OP_RD),    16'hFFFB, 5'd16},
    {3'(OP_FAULT), 16'h0000, 5'd2 },   // R5 class 1 below 3
    {3'(OP_TICKRD),16'h0200, 5'd16},
    {3'(OP_FAULT), 16'h0000, 5'd16},   // R8 frame 9 must stay class 3
    {3'(OP_FAULT), 16'h0000, 5'd16}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int best_cat();
    int b = 3;
    for (int i = 0; i < NF; i++)
      if (2 * int'(m_ref[i]) + int'(m_mod[i]) < b) b = 2 * int'(m_ref[i]) + int'(m_mod[i]);
    return b;
  endfunction

  task automatic access(input int f, input bit wr);
    acc_valid_i = 1'b1; acc_frame_i = 4'(f); acc_write_i = wr;
    @(negedge clk_i);
    acc_valid_i = 1'b0; acc_write_i = 1'b0;
    m_ref[f] = 1'b1;
    if (wr) m_mod[f] = 1'b1;
  endtask

  task automatic fault(input int exp, input string req);
    int bc = best_cat();
    fault_req_i = 1'b1;
    @(negedge clk_i);
    fault_req_i = 1'b0;
    check(victim_valid_o === 1'b1, "R7", int'(victim_valid_o), 1);
    check(2 * int'(m_ref[victim_o]) + int'(m_mod[victim_o]) == bc, "R5",
          2 * int'(m_ref[victim_o]) + int'(m_mod[victim_o]), bc);
    if (exp < NF) check(int'(victim_o) == exp, req, int'(victim_o), exp);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(victim_valid_o === 1'b0, "R3", int'(victim_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_ref = '0; m_mod = '0;
    @(negedge clk_i);
  endtask

  initial begin
    #(8 * 20000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    do_reset();
    check(victim_valid_o === 1'b0, "R7", int'(victim_valid_o), 0);

    for (int s = 0; s < N_STEPS; s++) begin
      int op = int'(STEPS[s][23:21]);
      logic [NF-1:0] mask = STEPS[s][20:5];
      int ex = int'(STEPS[s][4:0]);
      case (op)
        OP_RD:  for (int f = 0; f < NF; f++) if (mask[f]) access(f, 1'b0);
        OP_WR:  for (int f = 0; f < NF; f++) if (mask[f]) access(f, 1'b1);
        OP_TICK: begin
          tick_i = 1'b1; @(negedge clk_i); tick_i = 1'b0; m_ref = '0;
        end
        OP_TICKRD: begin
          tick_i = 1'b1;
          m_ref = '0;
          for (int f = 0; f < NF; f++) if (mask[f]) access(f, 1'b0); // R8
          tick_i = 1'b0;
        end
        default: fault(ex, "R5");
      endcase
    end

    // R7: valid drops the cycle after
    @(negedge clk_i);
    check(victim_valid_o === 1'b0, "R7", int'(victim_valid_o), 0);

    // R3: history wiped by reset mid-run
    for (int f = 0; f < NF; f++) if (f != 11) access(f, 1'b1);
    do_reset();
    for (int f = 0; f < NF; f++) if (f != 13) access(f, 1'b0);
    fault(13, "R3");

    // R9: colliding access ignored by the same-cycle pick
    do_reset();
    for (int f = 0; f < NF; f++) if (f != 6) access(f, 1'b0);
    acc_valid_i = 1'b1; acc_frame_i = 4'd6; acc_write_i = 1'b1;
    fault(6, "R9");
    acc_valid_i = 1'b0; acc_write_i = 1'b0;
    m_ref[6] = 1'b1; m_mod[6] = 1'b1;
    // frame 6 now class 3, others class 2
    for (int f = 0; f < NF; f++) if (f != 6) access(f, 1'b0);
    fault(16, "R2");

    // R6: uniform class gives spread of victims
    do_reset();
    begin
      logic [NF-1:0] seen = '0;
      for (int k = 0; k < 15; k++) begin
        fault(16, "R6");
        seen[victim_o] = 1'b1;
      end
      check($countones(seen) >= 8, "R6", $countones(seen), 8);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule